// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor over many clock cycles and produces one quotient bit per cycle. A client puts both operands on the inputs and pulses `start` while the block is idle. The block captures the operands, clears a partial remainder and then runs one iteration per cycle.

Each iteration shifts the remainder and the working dividend left together as one long register. The remainder is kept with a sign, and its sign picks the operation for that step: the divisor is subtracted when the remainder is non-negative and added when it is negative. No restore step is ever taken. The inverted sign of the new remainder is the next quotient bit. These bits collect in the dividend register as the original dividend bits move out of it.

After the last iteration, one more shift places the final quotient bit. If the remainder is negative at that point, the divisor is added back once. The block then publishes the quotient, the remainder and a success status, and pulses `done`. A divisor of zero is caught when `start` is accepted. In that case the block performs no iterations and answers at once with a failure status.

Top module: `nr_divider`

## Requirements
- R1: While reset is asserted and after it is released, before any operation, `busy`, `done`, `status`, `quotient` and `remainder` are all zero.
- R2: A `start` pulse seen while idle with a non-zero divisor makes `busy` high from the next cycle on.
- R3: A `start` with a divisor of zero performs no iterations. In the next cycle `done` is 1, `status` is 0 (failure), `quotient` and `remainder` are 0, and `busy` stays low.
- R4: For a non-zero divisor, `status` is 1 (success) when `done` is high, and `quotient` equals the dividend divided by the divisor, rounded down, over the full dividend width.
- R5: For a non-zero divisor, `remainder` equals the dividend modulo the divisor, so it always lies between 0 and divisor-1.
- R6: When `start` is accepted at clock edge k with a non-zero divisor, `busy` is high after edges k through k+DW. `done` is high, and `busy` is low, only after edge k+DW+1. DW is the dividend width.
- R7: `done` is high for exactly one cycle per operation.
- R8: A `start` pulse while `busy` is high is ignored. It does not change the running operation or its result.
- R9: `quotient`, `remainder` and `status` keep their values after `done` until the next operation completes.
- R10: The operands are captured when `start` is accepted. Changes on `dividend_i` or `divisor_i` during the operation do not affect the result, and the captured divisor stays unchanged throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| start | input | 1 | Request to begin a division; honoured only while idle |
| dividend_i | input | DW | Unsigned dividend (default 48) |
| divisor_i | input | VW | Unsigned divisor (default 24) |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 1 | 1 = success, 0 = divide by zero |
| quotient | output | DW | Quotient of the last completed operation |
| remainder | output | VW | Remainder of the last completed operation |

## Verification
The bench builds the divider with an 8-bit dividend and a 4-bit divisor. At that size every operand pair fits into one sweep, including the zero divisor, a divisor of 1 and the largest divisor. Every sign pattern of the non-restoring recurrence occurs, and so does the case where the final remainder must be corrected. Latency, `busy` and the one-cycle `done` pulse are timed on every operation. Operand inputs are changed in the middle of every run, and stray `start` pulses are injected for one divisor value to confirm that these stimuli are ignored.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_LAST = 2'd2
  } nrdiv_state_e;
endpackage

// File: rtl/nrdiv_ctrl.sv
// Sequencer: accepts start, loads the iteration count, steps it down and
// issues the final shift / publish strobe.
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int DW = 48,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          div_zero,
  output logic          busy_o,
  output logic          load_o,
  output logic          iter_o,
  output logic          last_o,
  output logic          fail_o,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);

  nrdiv_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    iter_o  = 1'b0;
    last_o  = 1'b0;
    fail_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (div_zero) begin
            fail_o = 1'b1;
            done_d = 1'b1;
          end else begin
            load_o  = 1'b1;
            cnt_d   = CW'(DW);
            state_d = ST_ITER;
          end
        end
      end
      ST_ITER: begin
        iter_o = 1'b1;
        cnt_d  = cnt_q - CW'(1);
        if (cnt_q == CW'(1)) state_d = ST_LAST;
      end
      ST_LAST: begin
        last_o  = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/nrdiv_step.sv
// One non-restoring iteration: shift in the next dividend bit, then add or
// subtract the divisor according to the sign of the old partial remainder.
module nrdiv_step #(
  parameter int VW = 24,
  localparam int RW = VW + 2
) (
  input  logic [RW-1:0] rem_i,
  input  logic          bit_i,
  input  logic [VW-1:0] divisor_i,
  output logic [RW-1:0] rem_o,
  output logic          qbit_o
);

  logic [RW-1:0] shifted;
  logic [RW-1:0] dext;

  always_comb begin
    shifted = {rem_i[RW-2:0], bit_i};
    dext    = {2'b00, divisor_i};
    rem_o   = rem_i[RW-1] ? (shifted + dext) : (shifted - dext);
    qbit_o  = ~rem_o[RW-1];
  end

endmodule

// File: rtl/nrdiv_fixup.sv
// Final remainder correction: one add-back when the last remainder is negative.
module nrdiv_fixup #(
  parameter int VW = 24
) (
  input  logic [VW-1:0] rem_low_i,
  input  logic          rem_neg_i,
  input  logic [VW-1:0] divisor_i,
  output logic [VW-1:0] rem_o
);

  always_comb begin
    rem_o = rem_neg_i ? (rem_low_i + divisor_i) : rem_low_i;
  end

endmodule

// File: rtl/nr_divider.sv
module nr_divider #(
  parameter int DW          = 48,
  parameter int VW          = 24,
  parameter int SYNC_STAGES = 2,
  localparam int RW = VW + 2,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic          busy,
  output logic          done,
  output logic          status,
  output logic [DW-1:0] quotient,
  output logic [VW-1:0] remainder
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_sync_n;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync_q <= '0;
        else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync_q <= '0;
        else        rsync_q <= 1'b1;
      end
    end
  endgenerate
  assign rst_sync_n = rsync_q[SYNC_STAGES-1];

  // Control
  logic          load_w, iter_w, last_w, fail_w;
  logic [CW-1:0] cnt_w;
  logic          div_zero;

  assign div_zero = (divisor_i == '0);

  nrdiv_ctrl #(.DW(DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .div_zero (div_zero),
    .busy_o   (busy),
    .load_o   (load_w),
    .iter_o   (iter_w),
    .last_o   (last_w),
    .fail_o   (fail_w),
    .done_o   (done),
    .cnt_o    (cnt_w)
  );

  // Working registers
  logic [RW-1:0] rem_q, rem_d;
  logic [DW-1:0] work_q, work_d;
  logic          qbit_q, qbit_d;
  logic [VW-1:0] div_q, div_d;
  logic          work_en;

  // Published results
  logic [DW-1:0] quo_out_q, quo_out_d;
  logic [VW-1:0] rem_out_q, rem_out_d;
  logic          stat_q, stat_d;
  logic          out_en;

  logic [RW-1:0] step_rem;
  logic          step_qbit;
  logic [VW-1:0] fixed_rem;

  nrdiv_step #(.VW(VW)) u_step (
    .rem_i     (rem_q),
    .bit_i     (work_q[DW-1]),
    .divisor_i (div_q),
    .rem_o     (step_rem),
    .qbit_o    (step_qbit)
  );

  nrdiv_fixup #(.VW(VW)) u_fix (
    .rem_low_i (rem_q[VW-1:0]),
    .rem_neg_i (rem_q[RW-1]),
    .divisor_i (div_q),
    .rem_o     (fixed_rem)
  );

  assign work_en = load_w | iter_w;
  assign out_en  = last_w | fail_w;

  always_comb begin
    rem_d  = rem_q;
    work_d = work_q;
    qbit_d = qbit_q;
    div_d  = div_q;
    if (load_w) begin
      rem_d  = '0;
      work_d = dividend_i;
      qbit_d = 1'b0;
      div_d  = divisor_i;
    end else if (iter_w) begin
      rem_d  = step_rem;
      work_d = {work_q[DW-2:0], qbit_q};
      qbit_d = step_qbit;
    end
  end

  always_comb begin
    quo_out_d = quo_out_q;
    rem_out_d = rem_out_q;
    stat_d    = stat_q;
    if (last_w) begin
      quo_out_d = {work_q[DW-2:0], qbit_q};
      rem_out_d = fixed_rem;
      stat_d    = 1'b1;
    end else if (fail_w) begin
      quo_out_d = '0;
      rem_out_d = '0;
      stat_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rem_q  <= '0;
      work_q <= '0;
      qbit_q <= 1'b0;
      div_q  <= '0;
    end else if (work_en) begin
      rem_q  <= rem_d;
      work_q <= work_d;
      qbit_q <= qbit_d;
      div_q  <= div_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      quo_out_q <= '0;
      rem_out_q <= '0;
      stat_q    <= 1'b0;
    end else if (out_en) begin
      quo_out_q <= quo_out_d;
      rem_out_q <= rem_out_d;
      stat_q    <= stat_d;
    end
  end

  assign quotient  = quo_out_q;
  assign remainder = rem_out_q;
  assign status    = stat_q;

endmodule

// File: rtl/nrdiv_checker.sv
module nrdiv_checker #(
  parameter int DW = 48,
  parameter int VW = 24,
  localparam int CW = $clog2(DW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          status,
  input logic [DW-1:0] quotient,
  input logic [VW-1:0] remainder,
  input logic [VW-1:0] div_q,
  input logic [CW-1:0] cnt
);

  assert_busy_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (div_q != '0));

  assert_zero_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !status) |-> (quotient == '0 && remainder == '0));

  assert_rem_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status) |-> (remainder < div_q));

  assert_count_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt == CW'(DW)));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  assert_divisor_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_q));

  assert_output_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(quotient) && $stable(remainder)));

endmodule

bind nr_divider nrdiv_checker #(.DW(DW), .VW(VW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .status    (status),
  .quotient  (quotient),
  .remainder (remainder),
  .div_q     (div_q),
  .cnt       (cnt_w)
);

// File: tb/nr_divider_test.sv
module nr_divider_test;
  localparam int DW = 8;
  localparam int VW = 4;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [DW-1:0] dividend_i;
  logic [VW-1:0] divisor_i;
  logic          busy, done, status;
  logic [DW-1:0] quotient;
  logic [VW-1:0] remainder;

  int checks = 0;
  int errors = 0;

  nr_divider #(.DW(DW), .VW(VW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy(busy), .done(done), .status(status),
    .quotient(quotient), .remainder(remainder)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic run_op(input int a, input int b, input bit inject);
    int steps = 0;
    bit busy_ok = 1'b1;
    int exp_q, exp_r, exp_s, exp_lat;
    logic [DW-1:0] held_q;
    @(negedge clk);
    start      = 1'b1;
    dividend_i = DW'(a);
    divisor_i  = VW'(b);
    exp_s   = (b != 0) ? 1 : 0;
    exp_q   = (b != 0) ? a / b : 0;
    exp_r   = (b != 0) ? a % b : 0;
    exp_lat = (b != 0) ? DW + 2 : 1;
    while (1) begin
      @(negedge clk);
      steps++;
      if (steps == 1) begin
        start      = 1'b0;
        dividend_i = ~DW'(a);     // R10: operands change after capture
        divisor_i  = ~VW'(b);
      end
      if (inject && steps == 3) begin
        start      = 1'b1;        // R8: stray start while busy
        dividend_i = '1;
        divisor_i  = VW'(1);
      end
      if (inject && steps == 4) start = 1'b0;
      if (done || steps > 200) break;
      if (!busy) busy_ok = 1'b0;
    end
    check(steps == exp_lat, "R6 latency", steps, exp_lat);
    if (b != 0) check(busy_ok, "R2 busy during iterations", int'(busy_ok), 1);
    else        check(busy_ok, "R3 busy stays low", int'(busy_ok), 1);
    check(!busy, "R6 busy low at done", int'(busy), 0);
    check(int'(status) == exp_s, (b != 0) ? "R4 status" : "R3 status", int'(status), exp_s);
    check(int'(quotient) == exp_q, inject ? "R8 quotient" : ((b != 0) ? "R4 quotient" : "R3 quotient"),
          int'(quotient), exp_q);
    check(int'(remainder) == exp_r, (b != 0) ? "R5 remainder" : "R3 remainder",
          int'(remainder), exp_r);
    held_q = quotient;
    @(negedge clk);
    check(!done, "R7 done one cycle", int'(done), 0);
    check(quotient == held_q && int'(remainder) == exp_r, "R9 outputs hold",
          int'(quotient), int'(held_q));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    dividend_i = '0;
    divisor_i  = '0;
    repeat (4) @(negedge clk);
    check(!busy && !done && !status, "R1 reset flags", int'({busy, done, status}), 0);
    check(quotient == '0 && remainder == '0, "R1 reset results", int'(quotient), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !status && quotient == '0 && remainder == '0,
          "R1 after release", int'({busy, done, status}), 0);
    for (int a = 0; a < (1 << DW); a++) begin
      for (int b = 0; b < (1 << VW); b++) begin
        run_op(a, b, (b == 5));
      end
    end
    // R9: results persist over a long idle stretch
    run_op(200, 7, 1'b0);
    repeat (20) @(negedge clk);
    check(int'(quotient) == 28 && int'(remainder) == 4 && status, "R9 long idle hold",
          int'(quotient), 28);
    report();
    $finish;
  end

endmodule